// File: doc/BRIEF.md
# Transmit FIFO Start-Threshold Controller

This block owns the byte-wide transmit buffer that sits between a host writer and a half-duplex MAC. It decides when the MAC may begin sending the preamble of the frame being loaded. Sending may begin once a programmable number of bytes is present, or as soon as the final byte of the frame has been written, whichever comes first. A two-bit start-point field selects the byte count. The field can only be changed while a stop control is held.

The block also keeps the head of the frame in the buffer until 64 bytes of it have left for the wire. Until then, a collision makes the read side rewind to the first byte, so the retry is served from the buffer without the host writing anything again. After 64 clean bytes the protected area is handed back to the writer. The block holds one frame at a time: after the final byte of a frame is written, the host is held off until the MAC has read that final byte.

Top module: `tx_start_gate`

## Requirements
- R1: With start-point code 00, 01, 10 or 11, `tx_go` goes high in the cycle after the 4th, 16th, 64th or 112th accepted byte of the current frame.
- R2: In the cycle after a byte carrying `wr_eof` is accepted, `tx_go` is high, whatever count the start-point field selects.
- R3: After reset the start-point code is 10 (64 bytes). Raising `cfg_stop` without a write does not change it.
- R4: A pulse on `cfg_wr` while `cfg_stop` is low has no effect on the start threshold.
- R5: `rd_valid` is high only while `tx_go` is high and unread bytes exist. Bytes come out in the order they were written, and `rd_last` marks the byte written with `wr_eof`.
- R6: Until 64 bytes of the current frame have been read, the buffer slots from the frame's first byte onward stay occupied. With the default depth of 128, `wr_ready` stays low once 128 bytes are held, even after reads.
- R7: A `col_retry` pulse while fewer than 64 bytes of the frame have been read rewinds the read side. `rd_data` then shows the frame's first byte, and `tx_go` stays high.
- R8: Once 64 bytes have been read without a collision, the slots already read are freed for writing, and a later `col_retry` leaves the read position unchanged.
- R9: When `col_retry` and an accepted read fall in the same cycle, the rewind wins. This holds even if the byte read is the last one: the frame is not finished, and `rd_data` shows the first byte.
- R10: After the `wr_eof` byte is accepted, `wr_ready` is low and writes are dropped until the last byte is read. In the cycle after that read, `tx_go` is low and `wr_ready` is high.
- R11: Out of reset, `tx_go` and `rd_valid` are low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stop | input | 1 | Stop control; must be high for a start-point write |
| cfg_wr | input | 1 | Start-point write strobe |
| cfg_sp | input | 2 | Start-point code: 00=4, 01=16, 10=64, 11=112 bytes |
| wr_en | input | 1 | Host write request |
| wr_data | input | 8 | Host write byte |
| wr_eof | input | 1 | Marks the written byte as the last of the frame |
| wr_ready | output | 1 | Write will be accepted this cycle |
| rd_en | input | 1 | MAC read request |
| rd_valid | output | 1 | A byte may be read (transmission permitted and data present) |
| rd_data | output | 8 | Byte at the read position |
| rd_last | output | 1 | Byte at the read position ends the frame |
| col_retry | input | 1 | Collision: replay the frame from its first byte |
| tx_go | output | 1 | Preamble transmission may start or continue |

## Verification
Two things can land in the same cycle: a collision rewind and a read advance. This includes the read of the frame's final byte, which would otherwise close the frame. The bench provokes this by raising `rd_en` and `col_retry` together on the final byte of a six-byte frame. It then checks that the read position shows the first byte again and that `tx_go` is still high. A second overlap is a late collision arriving after the protected window has been released. It is judged by checking that `rd_data` still shows byte 64 and that the freed slots accept a new write.

// File: rtl/txs_pkg.sv
// Package: shared types and the start-point decode for the transmit
// start-threshold controller. Assumes byte counts fit in CNT_W bits.
package txs_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        SP_4   = 2'b00,
        SP_16  = 2'b01,
        SP_64  = 2'b10,
        SP_112 = 2'b11
    } start_pt_e;

    // Byte count at which preamble may begin for a given start-point code.
    function automatic logic [CNT_W-1:0] sp_bytes(start_pt_e sp);
        case (sp)
            SP_4:    return CNT_W'(4);
            SP_16:   return CNT_W'(16);
            SP_64:   return CNT_W'(64);
            default: return CNT_W'(112);
        endcase
    endfunction

endpackage

// File: rtl/txs_startpt_reg.sv
// Start-point register: holds the two-bit threshold code. Loads only when
// the write strobe and the stop control are both high. Resets to the
// 64-byte code. Assumes stop is a level held by the configuring agent.
module txs_startpt_reg
    import txs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop,
    input  logic       wr,
    input  logic [1:0] sp_in,
    output start_pt_e  sp_q
);

    // Hold the code; accept new values only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= SP_64;
        else if (wr && stop)
            sp_q <= start_pt_e'(sp_in);
    end

    assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !stop |=> $stable(sp_q));

endmodule

// File: rtl/txs_store.sv
// Buffer storage: one write port and an asynchronous read port.
// Assumes DEPTH is a power of two and that the caller never writes a
// slot that is still in use.
module txs_store #(
    parameter int DW    = 9,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Write one entry per accepted byte.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Read entry at the read position, no latency.
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/txs_start_dec.sv
// Start decision: counts bytes accepted for the current frame and notes
// whether its final byte has arrived. Permits transmission at the selected
// threshold or at end of frame. Cleared when the frame is finished.
module txs_start_dec
    import txs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_acc,
    input  logic      wr_eof,
    input  logic      frame_done,
    input  start_pt_e sp,
    output logic      tx_go,
    output logic      eof_seen
);

    logic [CNT_W-1:0] cnt_q;
    logic             eof_q;

    // Track bytes written and end-of-frame for the frame being loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            eof_q <= 1'b0;
        end else if (frame_done) begin
            cnt_q <= '0;
            eof_q <= 1'b0;
        end else if (wr_acc) begin
            if (cnt_q != '1)
                cnt_q <= cnt_q + 1'b1;
            if (wr_eof)
                eof_q <= 1'b1;
        end
    end

    // Permit preamble once the threshold is met or the frame is complete.
    always_comb begin
        eof_seen = eof_q;
        tx_go    = eof_q || (cnt_q >= sp_bytes(sp));
    end

    assert_go_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_go) && $stable(sp) |-> $past(wr_acc));

endmodule

// File: rtl/txs_ptr_ctl.sv
// Pointer control: write, read and frame-base pointers. While fewer than
// PROT_BYTES of the current frame have been read, the frame base counts as
// occupied space, and a collision rewinds the read pointer to it. After
// that window the base is released and collisions are ignored.
// Assumes DEPTH is a power of two and PROT_BYTES <= DEPTH.
module txs_ptr_ctl #(
    parameter int DEPTH      = 128,
    parameter int PROT_BYTES = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int SW = $clog2(PROT_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc,
    input  logic          rd_acc,
    input  logic          rd_last,
    input  logic          col_retry,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          full,
    output logic          empty,
    output logic          frame_done
);

    logic [PW-1:0] wptr_q, rptr_q, base_q;
    logic [PW-1:0] oldest, used;
    logic [SW-1:0] sent_q;
    logic          prot_q;
    logic          retry;

    // Decode occupancy with the protected window counted as in use.
    always_comb begin
        retry      = col_retry && prot_q;
        frame_done = rd_acc && rd_last && !retry;
        oldest     = prot_q ? base_q : rptr_q;
        used       = wptr_q - oldest;
        full       = (used == PW'(DEPTH));
        empty      = (wptr_q == rptr_q);
        waddr      = wptr_q[AW-1:0];
        raddr      = rptr_q[AW-1:0];
    end

    // Advance the write pointer on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wptr_q <= '0;
        else if (wr_acc)
            wptr_q <= wptr_q + 1'b1;
    end

    // Read side: rewind on collision, advance on read, close or release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q <= '0;
            base_q <= '0;
            prot_q <= 1'b1;
            sent_q <= '0;
        end else if (retry) begin
            rptr_q <= base_q;
            sent_q <= '0;
        end else if (rd_acc) begin
            rptr_q <= rptr_q + 1'b1;
            if (rd_last) begin
                base_q <= rptr_q + 1'b1;
                prot_q <= 1'b1;
                sent_q <= '0;
            end else if (prot_q) begin
                if (sent_q == SW'(PROT_BYTES - 1))
                    prot_q <= 1'b0;
                else
                    sent_q <= sent_q + 1'b1;
            end
        end
    end

    assert_retry_rewinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        col_retry && prot_q |=> rptr_q == $past(base_q));

    assert_base_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prot_q && !frame_done |=> $stable(base_q));

    assert_late_col_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        col_retry && !prot_q && !rd_acc |=> $stable(rptr_q));

    assert_no_write_past_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |-> (used < PW'(DEPTH)));

endmodule

// File: rtl/tx_start_gate.sv
// Top: transmit start-threshold controller. Connects the start-point
// register, start decision, pointer control and storage. The host is held
// off after an end-of-frame byte until the MAC reads that byte.
module tx_start_gate #(
    parameter int DEPTH      = 128,
    parameter int DATA_W     = 8,
    parameter int PROT_BYTES = 64,
    localparam int AW  = $clog2(DEPTH),
    localparam int EW  = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stop,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sp,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eof,
    output logic              wr_ready,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    input  logic              col_retry,
    output logic              tx_go
);

    import txs_pkg::*;

    start_pt_e     sp_q;
    logic          eof_seen, full, empty, frame_done;
    logic          wr_acc, rd_acc;
    logic [AW-1:0] waddr, raddr;
    logic [EW-1:0] rdata;

    // Handshake qualification at the block edge.
    always_comb begin
        wr_ready = !full && !eof_seen;
        wr_acc   = wr_en && wr_ready;
        rd_valid = tx_go && !empty;
        rd_acc   = rd_en && rd_valid;
        rd_data  = rdata[DATA_W-1:0];
        rd_last  = rdata[DATA_W];
    end

    txs_startpt_reg u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .stop  (cfg_stop),
        .wr    (cfg_wr),
        .sp_in (cfg_sp),
        .sp_q  (sp_q)
    );

    txs_start_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_acc     (wr_acc),
        .wr_eof     (wr_eof),
        .frame_done (frame_done),
        .sp         (sp_q),
        .tx_go      (tx_go),
        .eof_seen   (eof_seen)
    );

    txs_ptr_ctl #(.DEPTH(DEPTH), .PROT_BYTES(PROT_BYTES)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_acc     (wr_acc),
        .rd_acc     (rd_acc),
        .rd_last    (rdata[DATA_W]),
        .col_retry  (col_retry),
        .waddr      (waddr),
        .raddr      (raddr),
        .full       (full),
        .empty      (empty),
        .frame_done (frame_done)
    );

    txs_store #(.DW(EW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (waddr),
        .wdata ({wr_eof, wr_data}),
        .raddr (raddr),
        .rdata (rdata)
    );

    assert_ready_after_eof_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_ready && wr_eof |=> !wr_ready);

    assert_valid_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> tx_go);

endmodule

// File: tb/tx_start_gate_bench.sv
module tx_start_gate_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_stop = 1'b0, cfg_wr = 1'b0;
    logic [1:0] cfg_sp = 2'b00;
    logic       wr_en = 1'b0, wr_eof = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_ready, rd_valid, rd_last, tx_go;
    logic       rd_en = 1'b0, col_retry = 1'b0;
    logic [7:0] rd_data;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tx_start_gate u_tx_start_gate (
        .clk(clk), .rst_n(rst_n), .cfg_stop(cfg_stop), .cfg_wr(cfg_wr),
        .cfg_sp(cfg_sp), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
        .wr_ready(wr_ready), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_last(rd_last), .col_retry(col_retry),
        .tx_go(tx_go)
    );

    // Stimulus table: {start-point code, frame length}; every frame ends with eof.
    localparam logic [9:0] VECS [0:5] = '{
        {2'b00, 8'd3}, {2'b00, 8'd10}, {2'b01, 8'd20},
        {2'b10, 8'd70}, {2'b11, 8'd120}, {2'b11, 8'd50}
    };

    function automatic int th_of(input logic [1:0] c);
        case (c)
            2'b00: return 4;
            2'b01: return 16;
            2'b10: return 64;
            default: return 112;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_sp(input logic [1:0] c);
        @(negedge clk); #1;
        cfg_stop = 1'b1; cfg_wr = 1'b1; cfg_sp = c;
        @(negedge clk); #1;
        cfg_wr = 1'b0; cfg_stop = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d, input logic e);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = d; wr_eof = e;
        @(negedge clk); #1;
        wr_en = 1'b0; wr_eof = 1'b0;
    endtask

    task automatic rd_byte(input string req, input logic [7:0] d, input logic last);
        @(negedge clk); #1;
        chk(req, "rd_valid", int'(rd_valid), 1);
        chk(req, "rd_data", int'(rd_data), int'(d));
        chk(req, "rd_last", int'(rd_last), int'(last));
        rd_en = 1'b1;
        @(negedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic col_pulse(input logic with_rd);
        @(negedge clk); #1;
        col_retry = 1'b1; rd_en = with_rd;
        @(negedge clk); #1;
        col_retry = 1'b0; rd_en = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11: reset state
        chk("R11", "tx_go", int'(tx_go), 0);
        chk("R11", "rd_valid", int'(rd_valid), 0);
        chk("R11", "wr_ready", int'(wr_ready), 1);

        // R3: stop alone keeps the 64-byte default; R4: write without stop ignored
        @(negedge clk); #1; cfg_stop = 1'b1;
        repeat (3) @(negedge clk);
        #1; cfg_stop = 1'b0;
        @(negedge clk); #1; cfg_wr = 1'b1; cfg_sp = 2'b00;
        @(negedge clk); #1; cfg_wr = 1'b0;
        for (int i = 1; i <= 64; i++) begin
            wr_byte(8'(i), 1'b0);
            if (i == 4)  chk("R4", "tx_go after 4 bytes", int'(tx_go), 0);
            if (i == 63) chk("R3", "tx_go after 63 bytes", int'(tx_go), 0);
            if (i == 64) chk("R3", "tx_go after 64 bytes", int'(tx_go), 1);
        end
        wr_byte(8'hE5, 1'b1);
        for (int i = 1; i <= 64; i++) rd_byte("R5", 8'(i), 1'b0);
        rd_byte("R5", 8'hE5, 1'b1);
        @(negedge clk); #1;
        chk("R10", "tx_go after frame", int'(tx_go), 0);

        // Table walk: R1 thresholds, R2 eof start, R5 ordering
        for (int k = 0; k < 6; k++) begin
            automatic logic [1:0] c = VECS[k][9:8];
            automatic int len = int'(VECS[k][7:0]);
            automatic int th = th_of(c);
            set_sp(c);
            for (int i = 1; i <= len; i++) begin
                wr_byte(8'(k * 37 + i), (i == len));
                chk((i == len && i < th) ? "R2" : "R1", "tx_go",
                    int'(tx_go), ((i >= th) || (i == len)) ? 1 : 0);
            end
            for (int i = 1; i <= len; i++)
                rd_byte("R5", 8'(k * 37 + i), (i == len));
            @(negedge clk); #1;
            chk("R10", "tx_go cleared", int'(tx_go), 0);
            chk("R10", "wr_ready restored", int'(wr_ready), 1);
        end

        // R7: collision inside window rewinds
        set_sp(2'b00);
        for (int i = 0; i < 10; i++) wr_byte(8'(8'h40 + i), (i == 9));
        for (int i = 0; i < 5; i++) rd_byte("R7", 8'(8'h40 + i), 1'b0);
        col_pulse(1'b0);
        chk("R7", "rd_data after rewind", int'(rd_data), 8'h40);
        chk("R7", "tx_go after rewind", int'(tx_go), 1);
        for (int i = 0; i < 10; i++) rd_byte("R7", 8'(8'h40 + i), (i == 9));

        // R9: collision together with read of the last byte
        for (int i = 0; i < 6; i++) wr_byte(8'(8'h60 + i), (i == 5));
        for (int i = 0; i < 5; i++) rd_byte("R9", 8'(8'h60 + i), 1'b0);
        @(negedge clk); #1;
        chk("R9", "rd_last before clash", int'(rd_last), 1);
        col_retry = 1'b1; rd_en = 1'b1;
        @(negedge clk); #1;
        col_retry = 1'b0; rd_en = 1'b0;
        chk("R9", "rd_data after clash", int'(rd_data), 8'h60);
        chk("R9", "tx_go after clash", int'(tx_go), 1);
        for (int i = 0; i < 6; i++) rd_byte("R9", 8'(8'h60 + i), (i == 5));

        // R6/R8: protection window and release
        for (int i = 0; i < 128; i++) wr_byte(8'(i), 1'b0);
        chk("R6", "wr_ready when full", int'(wr_ready), 0);
        for (int i = 0; i < 63; i++) rd_byte("R6", 8'(i), 1'b0);
        chk("R6", "wr_ready inside window", int'(wr_ready), 0);
        rd_byte("R6", 8'd63, 1'b0);
        @(negedge clk); #1;
        chk("R8", "wr_ready after release", int'(wr_ready), 1);
        col_pulse(1'b0);
        chk("R8", "rd_data after late collision", int'(rd_data), 64);
        wr_byte(8'hAA, 1'b1);
        for (int i = 64; i < 128; i++) rd_byte("R8", 8'(i), 1'b0);
        rd_byte("R8", 8'hAA, 1'b1);

        // R10: writes dropped after eof until the frame is read
        set_sp(2'b10);
        for (int i = 0; i < 3; i++) wr_byte(8'(8'h20 + i), (i == 2));
        chk("R10", "wr_ready after eof", int'(wr_ready), 0);
        wr_byte(8'h55, 1'b0);
        for (int i = 0; i < 3; i++) rd_byte("R10", 8'(8'h20 + i), (i == 2));
        @(negedge clk); #1;
        chk("R10", "rd_valid no stray byte", int'(rd_valid), 0);
        chk("R10", "tx_go after last read", int'(tx_go), 0);
        chk("R10", "wr_ready after last read", int'(wr_ready), 1);

        finish_up();
    end

endmodule